// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is the interrupt enable and flag register of a small 8-bit controller. It sits on a byte-wide register bus and holds eight bits: three sticky event flags, three source enables, a peripheral-group enable and a global enable. Three sources feed it. The first is a timer overflow pulse. The second is an external interrupt pin, which passes through a synchronizer and is detected on its rising edge. The third is a change detector that watches every pin of an 8-bit input port, limited by a per-pin mask.

A flag latches whenever its event occurs, whatever the enables hold. Only a software write of 0 clears it. The single interrupt request output combines each flag with its enable and adds a peripheral request input, gated by the peripheral-group enable. The global enable gates all of these. The register answers at four mirrored bus addresses, and all four reach the same storage.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset, bits 7 to 1 of the register read 0 and `irq` is 0. The reset value of bit 0 is unspecified and is not checked.
- R2: The register sits at every address whose low 7 bits are 0x0B: 0x0B, 0x8B, 0x10B and 0x18B. A write at any of these reaches the same storage and a read at any of them returns it. A read at any other address returns 0, and a write there leaves the register unchanged.
- R3: A write stores all 8 bits with this layout: bit 7 global enable, bit 6 peripheral-group enable, bit 5 timer enable, bit 4 external-pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external-pin flag, bit 0 port-change flag. The next read returns the stored byte.
- R4: `tmr_tick` high at a clock edge sets bit 2 at that edge, whatever the state of any enable.
- R5: A flag stays set until software writes 0 to it. Writing 1 to other bits does not clear it.
- R6: When a hardware set and a software clear of the same flag fall on the same edge, the flag ends up set.
- R7: `irq` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req`)), combinationally from the register and `periph_req`.
- R8: A rising edge on `ext_pin` sets bit 1 on the third clock edge after the pin rises, after two synchronizer stages and one edge-detect stage. A falling edge does not set the flag.
- R9: A change in either direction on any port pin whose `port_mask` bit is 1 sets bit 0 on the third clock edge after the change. Changes on pins whose mask bit is 0 leave bit 0 unchanged.
- R10: When bit 6 is 0, `periph_req` has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the register on an address hit, 0 otherwise |
| tmr_tick | input | 1 | Timer overflow event, one clock wide, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | 8 | Input port pins, asynchronous |
| port_mask | input | 8 | Per-pin change-detect enable |
| periph_req | input | 1 | Combined request from the peripheral group |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `tmr_tick` is synchronous to `clk` and that the bus inputs are stable around each clock edge. They also assume that the port and external pins are held low through reset, so that no false change is seen as the synchronizers fill. The bench drives every input on the falling edge and keeps the pins quiet while it sweeps the register contents. It raises one event at a time, so each flag can be traced to its own cause.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int CSR_W = 8;

  typedef struct packed {
    logic gie;
    logic pie;
    logic tmr_en;
    logic ext_en;
    logic chg_en;
    logic tmr_flg;
    logic ext_flg;
    logic chg_flg;
  } csr_t;

  // Request equation: per-source gating under the global enable,
  // plus the peripheral group gated by its own enable.
  function automatic logic irq_eval(csr_t c, logic preq);
    logic any_src;
    any_src = (c.tmr_en & c.tmr_flg) | (c.ext_en & c.ext_flg) |
              (c.chg_en & c.chg_flg) | (c.pie & preq);
    return c.gie & any_src;
  endfunction

  // Address decode with don't-care bank bits.
  function automatic logic addr_match(logic [8:0] a, logic [8:0] base,
                                      logic [8:0] bank_mask);
    return ((a ^ base) & ~bank_mask) == '0;
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic rise,
  output logic toggle
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign sync_out = chain_q[STAGES-1];
  assign rise     = sync_out & ~prev_q;
  assign toggle   = sync_out ^ prev_q;

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] mask,
  output logic         change_any
);
  logic [W-1:0] sync_v, rise_v, tog_v;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      irq_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins[i]),
        .sync_out(sync_v[i]), .rise(rise_v[i]), .toggle(tog_v[i]));
    end
  endgenerate

  assign change_any = |(tog_v & mask);

  // R9
  masked_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !change_any);
  // R9
  masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_v & mask)) |-> change_any);
  // R9
  sync_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tog_v & mask & sync_v)) |-> change_any);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 9,
  parameter int          PORT_W    = 8,
  parameter int          SYNC_N    = 2,
  parameter logic [8:0]  BASE_ADDR = 9'h00B,
  parameter logic [8:0]  BANK_MASK = 9'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CSR_W-1:0]  bus_wdata,
  output logic [CSR_W-1:0]  bus_rdata,
  input  logic              tmr_tick,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] port_mask,
  input  logic              periph_req,
  output logic              irq
);
  csr_t csr_q, csr_d;
  logic hit, wr_hit;
  logic ext_rise, ext_sync, ext_tog;
  logic chg_any;

  assign hit    = addr_match(bus_addr, BASE_ADDR, BANK_MASK);
  assign wr_hit = hit & bus_wr;

  irq_sync_edge #(.STAGES(SYNC_N)) u_ext (
    .clk(clk), .rst_n(rst_n), .async_in(ext_pin),
    .sync_out(ext_sync), .rise(ext_rise), .toggle(ext_tog));

  irq_port_watch #(.W(PORT_W), .STAGES(SYNC_N)) u_port (
    .clk(clk), .rst_n(rst_n), .pins(port_pins), .mask(port_mask),
    .change_any(chg_any));

  always_comb begin
    csr_d = csr_q;
    if (wr_hit) csr_d = csr_t'(bus_wdata);
    // hardware set applied after the write: set wins
    csr_d.tmr_flg = csr_d.tmr_flg | tmr_tick;
    csr_d.ext_flg = csr_d.ext_flg | ext_rise;
    csr_d.chg_flg = csr_d.chg_flg | chg_any;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;

  assign bus_rdata = hit ? CSR_W'(csr_q) : '0;
  assign irq       = irq_eval(csr_q, periph_req);

  // R4 R6
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> csr_q.tmr_flg);
  // R5
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q.tmr_flg && !(wr_hit && !bus_wdata[2])) |=> csr_q.tmr_flg);
  // R8
  ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> csr_q.ext_flg);
  // R8
  ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |-> (ext_tog && ext_sync));
  // R9
  chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |=> csr_q.chg_flg);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_q.gie |-> !irq);
  // R10
  periph_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_q.pie && !csr_q.tmr_en && !csr_q.ext_en && !csr_q.chg_en) |-> !irq);
  // R3
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !tmr_tick && !ext_rise && !chg_any) |=>
      (CSR_W'(csr_q) == $past(bus_wdata)));
  // R2
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit && !tmr_tick && !ext_rise && !chg_any) |=> $stable(csr_q));
endmodule

// File: tb/sim_irq_ctl_reg.sv
module sim_irq_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] REG = 9'h00B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic tmr_tick = 1'b0, ext_pin = 1'b0, periph_req = 1'b0, irq;
  logic [7:0] port_pins = '0, port_mask = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl_reg u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_tick(tmr_tick), .ext_pin(ext_pin), .port_pins(port_pins),
    .port_mask(port_mask), .periph_req(periph_req), .irq(irq));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_irq(logic [7:0] v, logic p);
    return v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & p));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    wait_n(3); rst_n = 1'b1; wait_n(1);
    // R1 reset state
    rd(REG, d); check("R1 reset bits", d & 8'hFE, 8'h00);
    check("R1 irq at reset", {7'd0, irq}, 8'h00);

    // R3 R7 R10 sweep all register values and periph_req
    for (int v = 0; v < 256; v++) begin
      wr(REG, v[7:0]);
      for (int p = 0; p < 2; p++) begin
        periph_req = p[0];
        rd(REG, d); check("R3 readback", d, v[7:0]);
        check(v[6] ? "R7 irq" : "R10 irq pie off", {7'd0, irq},
              {7'd0, exp_irq(v[7:0], p[0])});
      end
    end
    periph_req = 1'b0;

    // R2 mirrors
    wr(9'h18B, 8'hA0);
    rd(9'h00B, d); check("R2 mirror 0x0B", d, 8'hA0);
    rd(9'h08B, d); check("R2 mirror 0x8B", d, 8'hA0);
    rd(9'h10B, d); check("R2 mirror 0x10B", d, 8'hA0);
    wr(9'h00C, 8'h55);
    rd(9'h10B, d); check("R2 miss write ignored", d, 8'hA0);
    rd(9'h00C, d); check("R2 miss read zero", d, 8'h00);
    wr(9'h08B, 8'h48);
    rd(9'h18B, d); check("R2 write via 0x8B", d, 8'h48);

    // R4 timer flag with all enables off
    wr(REG, 8'h00);
    @(negedge clk); tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
    rd(REG, d); check("R4 timer flag", d, 8'h04);
    check("R7 no irq gie off", {7'd0, irq}, 8'h00);
    // R5 sticky against other writes
    wr(REG, 8'hA4 & 8'hFB | 8'h20);
    rd(REG, d); check("R5 write0 clears", d, 8'hA0);
    @(negedge clk); tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
    wr(REG, 8'hA4);
    wait_n(3);
    rd(REG, d); check("R5 flag held", d, 8'hA4);
    check("R7 irq timer", {7'd0, irq}, 8'h01);
    // R6 set wins over clear
    @(negedge clk); bus_addr = REG; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tmr_tick = 1'b0;
    rd(REG, d); check("R6 set wins", d, 8'h04);

    // R8 external pin timing
    wr(REG, 8'h00);
    @(negedge clk); ext_pin = 1'b1;
    wait_n(2); rd(REG, d); check("R8 ext not yet", d, 8'h00);
    wait_n(1); rd(REG, d); check("R8 ext set", d, 8'h02);
    wr(REG, 8'h00);
    @(negedge clk); ext_pin = 1'b0;
    wait_n(4); rd(REG, d); check("R8 falling ignored", d, 8'h00);

    // R9 port change
    port_mask = 8'h0F;
    @(negedge clk); port_pins = 8'h80;
    wait_n(4); rd(REG, d); check("R9 unmasked ignored", d, 8'h00);
    @(negedge clk); port_pins = 8'h84;
    wait_n(2); rd(REG, d); check("R9 chg not yet", d, 8'h00);
    wait_n(1); rd(REG, d); check("R9 chg rise", d, 8'h01);
    wr(REG, 8'h00);
    @(negedge clk); port_pins = 8'h80;
    wait_n(3); rd(REG, d); check("R9 chg fall", d, 8'h01);

    finish_run();
  end
endmodule